// File: doc/BRIEF.md
# Bidirectional GPIO Port Data Register

This block is the data register of a 16-pin general-purpose port. Every pin has a direction bit and a two-bit function code. Both come in as input ports from configuration registers held elsewhere. A pin can be ordinary I/O, timing-pattern output, or a pin lent to some other peripheral. A bus write stores data into the register one byte lane at a time. A bus read returns, for each bit, either the stored value or the synchronized pin level. The direction bit alone picks which one.

The block also drives the pad controls, a data value and an output enable for each pin. For a timing-pattern pin the pad data comes from an external pattern source. The pattern generator, the interrupt logic and the other peripherals are outside the block, so their signals arrive as plain inputs.

Only the power-on reset clears the stored data. A manual reset and the low-power indication leave it untouched. Both of them act only on the pin-input synchronizer.

Top module: `gpio_pdr`

## Requirements
- R1: A synchronous power-on reset (`por_rst` high at a clock edge) clears all 16 stored bits and both synchronizer stages to 0.
- R2: For a bit whose direction is input (`dir_out` bit = 0), `rd_data` returns the pin level from `pin_in`. That level passes through two clocked stages, so a change is seen after two rising edges.
- R3: For a bit whose direction is output (`dir_out` bit = 1), `rd_data` returns the stored bit, whatever its function code is.
- R4: A write (`wr_en` = 1) updates bits 7:0 only when `wr_be[0]` = 1 and bits 15:8 only when `wr_be[1]` = 1. The stored value shows on `rd_data` one edge after the write.
- R5: A bit whose function code is 2'b01 (timing pattern) and whose `pat_en` bit is 1 ignores writes and keeps its stored value. A pattern bit with `pat_en` = 0 accepts writes.
- R6: `pad_oe` for a bit is 1 only when its direction is output and its function code is 2'b00 (ordinary I/O) or 2'b01 (timing pattern). Otherwise it is 0.
- R7: `pad_out` for a bit with function 2'b01 equals the matching `pat_data` bit. For every other function it equals the stored bit, so a write to an input or peripheral pin changes the stored value but never enables the pad.
- R8: A manual reset (`man_rst`) leaves the stored register unchanged and clears only the two synchronizer stages to 0.
- R9: While `lp_mode` is 1, the synchronizer stages hold their values, and the stored register is neither cleared nor altered except by bus writes.
- R10: Function code 2'b10 (other peripheral) and the unused code 2'b11 behave the same: writes are accepted and the output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| man_rst | input | 1 | Manual reset, synchronous, active high; clears only the synchronizer |
| lp_mode | input | 1 | Low-power indication; freezes the synchronizer |
| wr_en | input | 1 | Bus write strobe |
| wr_be | input | 2 | Byte-lane enables (bit 0 = bits 7:0, bit 1 = bits 15:8) |
| wr_data | input | 16 | Bus write data |
| rd_data | output | 16 | Bus read data |
| dir_out | input | 16 | Direction per pin, 1 = output |
| fn_sel | input | 32 | Function code per pin, bits [2i+1:2i] for pin i |
| pat_en | input | 16 | Timing-pattern next-data enable per pin |
| pat_data | input | 16 | Timing-pattern data per pin |
| pin_in | input | 16 | Asynchronous pin levels from the pads |
| pad_out | output | 16 | Pad output data |
| pad_oe | output | 16 | Pad output enable |

## Verification
The checker tests these properties on every clock:
- output-direction reads always match the stored bits;
- no pad is enabled for an input or peripheral pin;
- pattern pins carry `pat_data`;
- locked bits and disabled byte lanes never change;
- a manual reset leaves the register alone.

Only the bench scenarios can show the other behaviours:
- the two-edge latency of pin reads;
- the freezing of the synchronizer in low-power mode;
- the clearing of the synchronizer by manual reset;
- the exact merged values after partial and blocked writes.

A behavioural model in the bench follows every cycle of both directed and random traffic.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

    typedef enum logic [1:0] {
        PF_GPIO    = 2'b00,
        PF_PATTERN = 2'b01,
        PF_PERIPH  = 2'b10,
        PF_SPARE   = 2'b11
    } pin_fn_e;

    typedef struct packed {
        logic drive;        // pad output enable
        logic from_pattern; // pad data taken from pattern source
        logic lock;         // bus writes ignored
    } pin_ctl_t;

    function automatic pin_ctl_t decode_pin(input logic [1:0] code,
                                            input logic       is_out,
                                            input logic       nxt_en);
        pin_ctl_t c;
        pin_fn_e  f;
        f              = pin_fn_e'(code);
        c.drive        = is_out && ((f == PF_GPIO) || (f == PF_PATTERN));
        c.from_pattern = (f == PF_PATTERN);
        c.lock         = (f == PF_PATTERN) && nxt_en;
        return c;
    endfunction

endpackage

// File: rtl/pdr_sync.sv
module pdr_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (clr) begin
            stage1 <= '0;
            stage2 <= '0;
        end else if (!hold) begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/pdr_store.sv
module pdr_store #(
    parameter int W      = 16,
    parameter int LANE_W = 8,
    localparam int NL    = W / LANE_W
) (
    input  logic          clk,
    input  logic          por_rst,
    input  logic          wr_en,
    input  logic [NL-1:0] wr_be,
    input  logic [W-1:0]  wr_data,
    input  logic [W-1:0]  lock,
    output logic [W-1:0]  q
);
    logic [W-1:0] bit_we;

    for (genvar b = 0; b < W; b++) begin : g_we
        assign bit_we[b] = wr_en && wr_be[b / LANE_W] && !lock[b];
    end

    always_ff @(posedge clk) begin
        if (por_rst) begin
            q <= '0;
        end else begin
            q <= (q & ~bit_we) | (wr_data & bit_we);
        end
    end
endmodule

// File: rtl/pdr_padmux.sv
module pdr_padmux
    import pdr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]   dir_out,
    input  logic [2*W-1:0] fn_sel,
    input  logic [W-1:0]   pat_en,
    input  logic [W-1:0]   pat_data,
    input  logic [W-1:0]   store_q,
    input  logic [W-1:0]   pin_sync,
    output logic [W-1:0]   rd_data,
    output logic [W-1:0]   pad_out,
    output logic [W-1:0]   pad_oe,
    output logic [W-1:0]   lock
);
    pin_ctl_t ctl [W];

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign ctl[i]     = decode_pin(fn_sel[2*i +: 2], dir_out[i], pat_en[i]);
        assign rd_data[i] = dir_out[i] ? store_q[i] : pin_sync[i];
        assign pad_oe[i]  = ctl[i].drive;
        assign pad_out[i] = ctl[i].from_pattern ? pat_data[i] : store_q[i];
        assign lock[i]    = ctl[i].lock;
    end
endmodule

// File: rtl/gpio_pdr.sv
module gpio_pdr #(
    parameter int PW     = 16,
    parameter int LANE_W = 8,
    localparam int NL    = PW / LANE_W
) (
    input  logic            clk,
    input  logic            por_rst,
    input  logic            man_rst,
    input  logic            lp_mode,
    input  logic            wr_en,
    input  logic [NL-1:0]   wr_be,
    input  logic [PW-1:0]   wr_data,
    output logic [PW-1:0]   rd_data,
    input  logic [PW-1:0]   dir_out,
    input  logic [2*PW-1:0] fn_sel,
    input  logic [PW-1:0]   pat_en,
    input  logic [PW-1:0]   pat_data,
    input  logic [PW-1:0]   pin_in,
    output logic [PW-1:0]   pad_out,
    output logic [PW-1:0]   pad_oe
);
    logic [PW-1:0] store_q;
    logic [PW-1:0] pin_sync;
    logic [PW-1:0] lock;
    logic          sync_clr;

    assign sync_clr = por_rst || man_rst;

    pdr_sync #(.W(PW)) u_sync (
        .clk  (clk),
        .clr  (sync_clr),
        .hold (lp_mode),
        .d    (pin_in),
        .q    (pin_sync)
    );

    pdr_store #(.W(PW), .LANE_W(LANE_W)) u_store (
        .clk     (clk),
        .por_rst (por_rst),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .lock    (lock),
        .q       (store_q)
    );

    pdr_padmux #(.W(PW)) u_mux (
        .dir_out  (dir_out),
        .fn_sel   (fn_sel),
        .pat_en   (pat_en),
        .pat_data (pat_data),
        .store_q  (store_q),
        .pin_sync (pin_sync),
        .rd_data  (rd_data),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .lock     (lock)
    );
endmodule

// File: rtl/pdr_checker.sv
module pdr_checker #(
    parameter int PW     = 16,
    parameter int LANE_W = 8,
    localparam int NL    = PW / LANE_W
) (
    input logic            clk,
    input logic            por_rst,
    input logic            man_rst,
    input logic            wr_en,
    input logic [NL-1:0]   wr_be,
    input logic [PW-1:0]   rd_data,
    input logic [PW-1:0]   dir_out,
    input logic [2*PW-1:0] fn_sel,
    input logic [PW-1:0]   pat_en,
    input logic [PW-1:0]   pat_data,
    input logic [PW-1:0]   pad_out,
    input logic [PW-1:0]   pad_oe,
    input logic [PW-1:0]   store_q
);
    logic [PW-1:0] is_pat;
    logic [PW-1:0] is_other;
    logic [PW-1:0] frozen;

    for (genvar i = 0; i < PW; i++) begin : g_m
        assign is_pat[i]   = (fn_sel[2*i +: 2] == 2'b01);
        assign is_other[i] = fn_sel[2*i+1];
        assign frozen[i]   = is_pat[i] & pat_en[i];
    end

    // R1
    assert_por_clears_R1: assert property (@(posedge clk)
        por_rst |=> (store_q == '0));

    // R3
    assert_out_read_R3: assert property (@(posedge clk) disable iff (por_rst)
        ((rd_data ^ store_q) & dir_out) == '0);

    // R4: disabled lanes never change
    for (genvar l = 0; l < NL; l++) begin : g_lane
        assert_lane_gate_R4: assert property (@(posedge clk) disable iff (por_rst)
            (wr_en && !wr_be[l]) |=> $stable(store_q[l*LANE_W +: LANE_W]));
    end

    // R5
    assert_locked_kept_R5: assert property (@(posedge clk) disable iff (por_rst)
        1'b1 |=> (((store_q ^ $past(store_q)) & $past(frozen)) == '0));

    // R6 / R10
    assert_oe_rule_R6: assert property (@(posedge clk) disable iff (por_rst)
        (pad_oe & (~dir_out | is_other)) == '0);

    // R7
    assert_pat_drive_R7: assert property (@(posedge clk) disable iff (por_rst)
        ((pad_out ^ pat_data) & is_pat) == '0);

    // R8
    assert_manrst_keeps_R8: assert property (@(posedge clk) disable iff (por_rst)
        (man_rst && !wr_en) |=> $stable(store_q));
endmodule

bind gpio_pdr pdr_checker #(.PW(PW), .LANE_W(LANE_W)) u_chk (
    .clk      (clk),
    .por_rst  (por_rst),
    .man_rst  (man_rst),
    .wr_en    (wr_en),
    .wr_be    (wr_be),
    .rd_data  (rd_data),
    .dir_out  (dir_out),
    .fn_sel   (fn_sel),
    .pat_en   (pat_en),
    .pat_data (pat_data),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .store_q  (store_q)
);

// File: tb/tb_gpio_pdr.sv
module tb_gpio_pdr;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        por_rst = 1, man_rst = 0, lp_mode = 0, wr_en = 0;
    logic [1:0]  wr_be = 0;
    logic [15:0] wr_data = 0, dir_out = 16'hFFFF, pat_en = 0, pat_data = 0, pin_in = 0;
    logic [31:0] fn_sel = 0;
    logic [15:0] rd_data, pad_out, pad_oe;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    logic [15:0] m_reg = 0, m_s1 = 0, m_s2 = 0, m_nx;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pdr dut (
        .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .lp_mode(lp_mode),
        .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data),
        .dir_out(dir_out), .fn_sel(fn_sel), .pat_en(pat_en), .pat_data(pat_data),
        .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always @(posedge clk) begin
        if (por_rst) begin
            m_reg <= 0; m_s1 <= 0; m_s2 <= 0;
        end else begin
            if (man_rst) begin
                m_s1 <= 0; m_s2 <= 0;
            end else if (!lp_mode) begin
                m_s1 <= pin_in; m_s2 <= m_s1;
            end
            m_nx = m_reg;
            if (wr_en)
                for (int i = 0; i < 16; i++)
                    if (wr_be[i/8] && !(fn_sel[2*i +: 2] == 2'b01 && pat_en[i]))
                        m_nx[i] = wr_data[i];
            m_reg <= m_nx;
        end
    end

    function automatic logic [15:0] exp_rd();
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = dir_out[i] ? m_reg[i] : m_s2[i];
        return r;
    endfunction

    function automatic logic [15:0] exp_oe();
        logic [15:0] r;
        for (int i = 0; i < 16; i++)
            r[i] = dir_out[i] && (fn_sel[2*i +: 2] == 2'b00 || fn_sel[2*i +: 2] == 2'b01);
        return r;
    endfunction

    function automatic logic [15:0] exp_out();
        logic [15:0] r;
        for (int i = 0; i < 16; i++)
            r[i] = (fn_sel[2*i +: 2] == 2'b01) ? pat_data[i] : m_reg[i];
        return r;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    string cur_req = "R1";

    task automatic tick();
        @(posedge clk);
        #1;
        chk(cur_req, rd_data, exp_rd());
        chk("R6", pad_oe, exp_oe());
        chk("R7", pad_out, exp_out());
    endtask

    task automatic wr(input logic [1:0] be, input logic [15:0] d);
        wr_en = 1; wr_be = be; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        por_rst = 0;
        tick();
        chk("R1", rd_data, 16'h0000);

        cur_req = "R3";
        wr(2'b11, 16'hA5C3);
        chk("R3", rd_data, 16'hA5C3);
        chk("R7", pad_out, 16'hA5C3);
        chk("R6", pad_oe, 16'hFFFF);

        cur_req = "R4";
        wr(2'b01, 16'hFFFF);
        chk("R4", rd_data, 16'hA5FF);
        wr(2'b10, 16'h0000);
        chk("R4", rd_data, 16'h00FF);

        // pattern on low byte, low nibble locked
        cur_req = "R5";
        fn_sel = 32'h0000_5555; pat_en = 16'h000F; pat_data = 16'h003C;
        wr(2'b11, 16'h1234);
        chk("R5", rd_data, 16'h123F);
        chk("R7", pad_out, 16'h123C);
        chk("R6", pad_oe, 16'hFFFF);
        pat_en = 16'h0000;
        wr(2'b01, 16'h0030);
        chk("R5", rd_data, 16'h1230);
        pat_en = 16'h000F;
        wr(2'b01, 16'h003F);
        chk("R5", rd_data, 16'h1230);

        // upper byte peripheral, pin 15 unused code
        cur_req = "R10";
        fn_sel = 32'hEAAA_5555;
        wr(2'b10, 16'hBE00);
        chk("R10", rd_data, 16'hBE30);
        chk("R10", pad_oe, 16'h00FF);
        chk("R7", pad_out, 16'hBE3C);

        // upper byte as input
        cur_req = "R2";
        fn_sel = 0; pat_en = 0; dir_out = 16'h00FF; pin_in = 16'h5A00;
        tick();
        chk("R2", rd_data, 16'h0030);
        tick();
        chk("R2", rd_data, 16'h5A30);
        chk("R6", pad_oe, 16'h00FF);
        wr(2'b11, 16'h0000);
        chk("R7", rd_data, 16'h5A00);
        chk("R7", pad_out, 16'h0000);
        dir_out = 16'hFFFF;
        #1 chk("R3", rd_data, 16'h0000);
        dir_out = 16'h00FF;

        // manual reset
        cur_req = "R8";
        wr(2'b11, 16'h7777);
        man_rst = 1;
        tick();
        man_rst = 0;
        chk("R8", rd_data, 16'h0077);
        tick(); tick();
        chk("R8", rd_data, 16'h5A77);

        // low power
        cur_req = "R9";
        lp_mode = 1; pin_in = 16'hC300;
        repeat (3) tick();
        chk("R9", rd_data, 16'h5A77);
        lp_mode = 0;
        tick(); tick();
        chk("R9", rd_data, 16'hC377);

        // power-on reset again
        cur_req = "R1";
        dir_out = 16'hFFFF;
        por_rst = 1;
        tick();
        chk("R1", rd_data, 16'h0000);
        por_rst = 0;
        dir_out = 16'h0000;
        tick();
        tick();
        chk("R1", rd_data, 16'hC300);

        // random traffic against the model
        cur_req = "R2";
        for (int n = 0; n < 600; n++) begin
            por_rst  = ($urandom_range(0, 63) == 0);
            man_rst  = ($urandom_range(0, 31) == 0);
            lp_mode  = ($urandom_range(0, 7) == 0);
            wr_en    = $urandom_range(0, 1);
            wr_be    = 2'($urandom);
            wr_data  = 16'($urandom);
            dir_out  = 16'($urandom);
            fn_sel   = $urandom;
            pat_en   = 16'($urandom);
            pat_data = 16'($urandom);
            pin_in   = 16'($urandom);
            cur_req  = (n % 2 == 0) ? "R3" : "R2";
            tick();
        end
        por_rst = 0; man_rst = 0; wr_en = 0;
        tick();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule